// File: doc/BRIEF.md
# Addressable Synapse Stimulus Register Bank

This block holds one activation bit for each synapse of a four-branch array, with two separate groups: excitatory and inhibitory. Each branch has fifteen synapses of each kind, indexed evenly along the branch. A controller arms synapses one at a time. It presents a synapse address together with a set strobe, and the decoder marks the selected bit.

Armed synapses do nothing until the shared active-low stimulate line is pulled low. For as long as it stays low, every armed synapse holds its active-low gate output low. A shared active-low clear line then disarms the whole bank at once, ready for the next round of arming. Arming and firing are separate in time, so many sources can arm synapses in sequence and all of them fire together.

All state is synchronous to `clk`. The gate outputs are registered, so every synapse starts and ends its pulse on the same clock edge.

Top module: `synapse_stim_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every activation bit is cleared and every gate output (`exc_gate_n`, `inh_gate_n`) is driven to 1 after that edge.
- R2: A clock edge with `set_en` high, `clear_n` high and a valid address arms exactly the addressed synapse. All other activation bits keep their values.
- R3: The address `syn_addr` is {branch[6:5], polarity[4], position[3:0]}. Polarity 0 selects the excitatory group and 1 selects the inhibitory group. The selected output bit index is branch*15 + position.
- R4: A set request whose position field is 15 arms no synapse in either group.
- R5: When `stim_n` is low at a clock edge, every armed synapse's gate output is 0 after that edge. When `stim_n` is high at an edge, every gate output is 1 after it.
- R6: A synapse that is not armed keeps its gate output at 1 while `stim_n` is low.
- R7: A clock edge with `clear_n` low disarms every synapse in both groups.
- R8: When `clear_n` is low and `set_en` is high at the same edge, the clear wins and the addressed synapse is not armed.
- R9: Arming a synapse in one polarity group leaves the same index in the other group unarmed.
- R10: A synapse armed at an edge where `stim_n` is already low takes part in firing only from the following edge. Its gate goes low one edge after the arming edge if `stim_n` stays low.
- R11: When `stim_n` and `clear_n` are both low at the same edge, the gates fire for that edge using the bits armed before the clear. At the next edge the gates return to 1.
- R12: Armed synapses stay armed across any number of stimulate pulses until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| set_en | input | 1 | Set strobe; arms the synapse at `syn_addr` |
| syn_addr | input | 7 | Synapse address {branch, polarity, position} |
| clear_n | input | 1 | Global active-low clear of all activation bits |
| stim_n | input | 1 | Global active-low stimulate impulse |
| exc_gate_n | output | 60 | Active-low excitatory gate enables, index branch*15+position |
| inh_gate_n | output | 60 | Active-low inhibitory gate enables, index branch*15+position |

## Verification
Three pairs of functions can meet in one cycle. Clear against set is provoked by asserting `clear_n` low and `set_en` high together. It is judged by a later stimulate pulse that must leave the addressed gate high. Stimulate against clear is provoked by holding both lines low at one edge. The gates must fire once from the old bits and release on the next edge. Set during an ongoing stimulate pulse must show the new gate low only one edge later.

// File: rtl/syn_stim_pkg.sv
package syn_stim_pkg;

    // Default array geometry
    localparam int DEF_BRANCHES   = 4;
    localparam int DEF_PER_BRANCH = 15;

    // Polarity field of the address
    typedef enum logic {
        POL_EXCITE  = 1'b0,
        POL_INHIBIT = 1'b1
    } syn_polarity_e;

    // Number of polarity groups held by the bank
    localparam int NUM_GROUPS = 2;

    // Width of a field able to hold values 0..n-1, at least one bit
    function automatic int field_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Flat output index of a synapse within its polarity group
    function automatic int unsigned flat_index(input int unsigned branch,
                                               input int unsigned pos,
                                               input int unsigned per_branch);
        return branch * per_branch + pos;
    endfunction

endpackage

// File: rtl/syn_addr_decoder.sv
module syn_addr_decoder
    import syn_stim_pkg::*;
#(
    parameter int NUM_BRANCHES = DEF_BRANCHES,
    parameter int PER_BRANCH   = DEF_PER_BRANCH,
    localparam int NSYN        = NUM_BRANCHES * PER_BRANCH,
    localparam int BW          = field_width(NUM_BRANCHES),
    localparam int PW          = field_width(PER_BRANCH + 1),
    localparam int AW          = BW + 1 + PW
) (
    input  logic                               set_en,
    input  logic [AW-1:0]                      addr,
    output logic [NUM_GROUPS-1:0][NSYN-1:0]    set_vec
);

    logic [BW-1:0]  br_f;
    logic [PW-1:0]  pos_f;
    syn_polarity_e  pol_f;
    logic           hit;
    int unsigned    idx;

    always_comb begin
        br_f  = addr[AW-1 -: BW];
        pol_f = syn_polarity_e'(addr[PW]);
        pos_f = addr[PW-1:0];
        hit   = set_en
              && ({1'b0, pos_f} < (PW+1)'(PER_BRANCH))
              && ({1'b0, br_f}  < (BW+1)'(NUM_BRANCHES));
        idx   = flat_index(32'(br_f), 32'(pos_f), PER_BRANCH);
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        for (genvar i = 0; i < NSYN; i++) begin : g_bit
            assign set_vec[g][i] = hit
                                 && (pol_f == syn_polarity_e'(g))
                                 && (idx == 32'(i));
        end
    end

    // At most one synapse in the whole bank is selected by any address (R3)
    always_comb begin
        if (!$isunknown({set_en, addr})) begin
            assert_single_select_R3: assert ($onehot0(set_vec))
                else $error("decoder selected more than one synapse");
        end
    end

    // An out-of-range position never produces a set (R4)
    always_comb begin
        if (!$isunknown({set_en, addr}) && ({1'b0, addr[PW-1:0]} >= (PW+1)'(PER_BRANCH))) begin
            assert_pos_ignored_R4: assert (set_vec == '0)
                else $error("set produced for out-of-range position");
        end
    end

endmodule

// File: rtl/syn_stim_reg.sv
module syn_stim_reg #(
    parameter int NSYN = 60
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear_n,
    input  logic [NSYN-1:0] set_vec,
    output logic [NSYN-1:0] armed
);

    always_ff @(posedge clk) begin
        if (rst || !clear_n) begin
            armed <= '0;
        end else begin
            armed <= armed | set_vec;
        end
    end

    // A clear empties the register on the next edge (R7)
    assert_clear_all_R7: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> (armed == '0))
        else $error("clear left bits armed");

    for (genvar i = 0; i < NSYN; i++) begin : g_chk
        // Set with clear released arms the bit (R2)
        assert_set_arms_R2: assert property (@(posedge clk) disable iff (rst)
            (clear_n && set_vec[i]) |=> armed[i])
            else $error("set did not arm bit %0d", i);

        // A bit only becomes armed through its own set (R2)
        assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(armed[i]) |-> $past(set_vec[i] && clear_n))
            else $error("bit %0d armed without set", i);

        // Clear overrides a simultaneous set (R8)
        assert_clear_wins_R8: assert property (@(posedge clk) disable iff (rst)
            (!clear_n && set_vec[i]) |=> !armed[i])
            else $error("set beat clear on bit %0d", i);

        // Armed bits persist without clear (R12)
        assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
            (armed[i] && clear_n) |=> armed[i])
            else $error("bit %0d dropped without clear", i);
    end

endmodule

// File: rtl/syn_gate_drive.sv
module syn_gate_drive #(
    parameter int NSYN = 60
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stim_n,
    input  logic [NSYN-1:0] armed,
    output logic [NSYN-1:0] gate_n
);

    logic [NSYN-1:0] fire;

    always_comb begin
        fire = stim_n ? '0 : armed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_n <= '1;
        end else begin
            gate_n <= ~fire;
        end
    end

    // Without stimulate every gate is released next edge (R5)
    assert_idle_release_R5: assert property (@(posedge clk) disable iff (rst)
        stim_n |=> (gate_n == '1))
        else $error("gate low without stimulate");

    for (genvar i = 0; i < NSYN; i++) begin : g_chk
        // Armed synapse fires during stimulate (R5)
        assert_fire_R5: assert property (@(posedge clk) disable iff (rst)
            (!stim_n && armed[i]) |=> !gate_n[i])
            else $error("armed synapse %0d did not fire", i);

        // Unarmed synapse stays quiet (R6)
        assert_quiet_R6: assert property (@(posedge clk) disable iff (rst)
            !armed[i] |=> gate_n[i])
            else $error("unarmed synapse %0d fired", i);
    end

endmodule

// File: rtl/synapse_stim_bank.sv
module synapse_stim_bank
    import syn_stim_pkg::*;
#(
    parameter int NUM_BRANCHES = DEF_BRANCHES,
    parameter int PER_BRANCH   = DEF_PER_BRANCH,
    localparam int NSYN        = NUM_BRANCHES * PER_BRANCH,
    localparam int AW          = field_width(NUM_BRANCHES) + 1 + field_width(PER_BRANCH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic [AW-1:0]   syn_addr,
    input  logic            clear_n,
    input  logic            stim_n,
    output logic [NSYN-1:0] exc_gate_n,
    output logic [NSYN-1:0] inh_gate_n
);

    logic [NUM_GROUPS-1:0][NSYN-1:0] set_vec;
    logic [NUM_GROUPS-1:0][NSYN-1:0] armed;
    logic [NUM_GROUPS-1:0][NSYN-1:0] gate_n;

    syn_addr_decoder #(
        .NUM_BRANCHES (NUM_BRANCHES),
        .PER_BRANCH   (PER_BRANCH)
    ) u_dec (
        .set_en  (set_en),
        .addr    (syn_addr),
        .set_vec (set_vec)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        syn_stim_reg #(.NSYN(NSYN)) u_reg (
            .clk     (clk),
            .rst     (rst),
            .clear_n (clear_n),
            .set_vec (set_vec[g]),
            .armed   (armed[g])
        );

        syn_gate_drive #(.NSYN(NSYN)) u_drv (
            .clk    (clk),
            .rst    (rst),
            .stim_n (stim_n),
            .armed  (armed[g]),
            .gate_n (gate_n[g])
        );
    end

    assign exc_gate_n = gate_n[int'(POL_EXCITE)];
    assign inh_gate_n = gate_n[int'(POL_INHIBIT)];

    // Groups are independent: one set never arms both polarities (R9)
    assert_group_split_R9: assert property (@(posedge clk) disable iff (rst)
        (clear_n && set_en) |=> ($countones(armed[0] ^ $past(armed[0]))
                               + $countones(armed[1] ^ $past(armed[1]))) <= 1)
        else $error("one set changed more than one bit");

endmodule

// File: tb/tb_synapse_stim_bank.sv
`timescale 1ns/1ps
module tb_synapse_stim_bank;

    localparam int N  = 60;
    localparam int SP = 15;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         set_en = 1'b0;
    logic [6:0]   syn_addr = '0;
    logic         clear_n = 1'b1;
    logic         stim_n = 1'b1;
    logic [N-1:0] exc_gate_n;
    logic [N-1:0] inh_gate_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [N-1:0] m_exc = '0;
    logic [N-1:0] m_inh = '0;

    always #4 clk = ~clk;

    synapse_stim_bank dut (
        .clk        (clk),
        .rst        (rst),
        .set_en     (set_en),
        .syn_addr   (syn_addr),
        .clear_n    (clear_n),
        .stim_n     (stim_n),
        .exc_gate_n (exc_gate_n),
        .inh_gate_n (inh_gate_n)
    );

    function automatic logic [6:0] mk(input int br, input int pol, input int pos);
        return {2'(br), 1'(pol), 4'(pos)};
    endfunction

    task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // One clock: apply inputs, advance, compare both groups to the model
    task automatic step(input logic se, input logic [6:0] a, input logic cn,
                        input logic sn, input string tag);
        logic [N-1:0] exp_e, exp_i;
        int idx;
        set_en = se; syn_addr = a; clear_n = cn; stim_n = sn;
        exp_e = ~(m_exc & {N{~sn}});
        exp_i = ~(m_inh & {N{~sn}});
        if (!cn) begin
            m_exc = '0; m_inh = '0;
        end else if (se && a[3:0] < 4'd15) begin
            idx = int'(a[6:5]) * SP + int'(a[3:0]);
            if (a[4]) m_inh[idx] = 1'b1; else m_exc[idx] = 1'b1;
        end
        @(posedge clk); #1;
        check_vec({tag, " exc"}, exc_gate_n, exp_e);
        check_vec({tag, " inh"}, inh_gate_n, exp_i);
    endtask

    task automatic idle(input string tag);
        step(1'b0, '0, 1'b1, 1'b1, tag);
    endtask

    task automatic wipe(input string tag);
        step(1'b0, '0, 1'b0, 1'b1, tag);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check_vec("R1 exc", exc_gate_n, '1);
        check_vec("R1 inh", inh_gate_n, '1);
        rst = 1'b0;
        idle("R1");
    endtask

    task automatic t_basic;
        step(1'b1, mk(1, 0, 3), 1'b1, 1'b1, "R2 set");
        idle("R2 hold");
        step(1'b0, '0, 1'b1, 1'b0, "R6 stim");
        check_bit("R3 index 18", exc_gate_n[18], 1'b0);
        check_bit("R5 fired", exc_gate_n[1*SP+3], 1'b0);
        idle("R5 release");
        check_bit("R5 released", exc_gate_n[18], 1'b1);
        wipe("R7");
    endtask

    task automatic t_pos15;
        step(1'b1, mk(2, 0, 15), 1'b1, 1'b1, "R4 set");
        step(1'b1, mk(0, 1, 15), 1'b1, 1'b1, "R4 set");
        step(1'b0, '0, 1'b1, 1'b0, "R4 stim");
        check_vec("R4 exc quiet", exc_gate_n, '1);
        check_vec("R4 inh quiet", inh_gate_n, '1);
        idle("R4");
    endtask

    task automatic t_polarity;
        step(1'b1, mk(3, 1, 7), 1'b1, 1'b1, "R9 set");
        step(1'b0, '0, 1'b1, 1'b0, "R9 stim");
        check_bit("R9 inh fired", inh_gate_n[3*SP+7], 1'b0);
        check_bit("R9 exc same idx", exc_gate_n[3*SP+7], 1'b1);
        idle("R9");
        wipe("R9 clr");
    endtask

    task automatic t_clear;
        step(1'b1, mk(0, 0, 0), 1'b1, 1'b1, "R7 a");
        step(1'b1, mk(3, 1, 14), 1'b1, 1'b1, "R7 b");
        wipe("R7 clr");
        step(1'b0, '0, 1'b1, 1'b0, "R7 stim");
        check_vec("R7 exc", exc_gate_n, '1);
        check_vec("R7 inh", inh_gate_n, '1);
        idle("R7");
    endtask

    task automatic t_clear_set;
        step(1'b1, mk(2, 0, 5), 1'b0, 1'b1, "R8 both");
        step(1'b0, '0, 1'b1, 1'b0, "R8 stim");
        check_bit("R8 not armed", exc_gate_n[2*SP+5], 1'b1);
        idle("R8");
    endtask

    task automatic t_set_in_stim;
        step(1'b0, '0, 1'b1, 1'b0, "R10 pre");
        step(1'b1, mk(1, 1, 9), 1'b1, 1'b0, "R10 set");
        check_bit("R10 not yet", inh_gate_n[1*SP+9], 1'b1);
        step(1'b0, '0, 1'b1, 1'b0, "R10 next");
        check_bit("R10 fired", inh_gate_n[1*SP+9], 1'b0);
        idle("R10");
        wipe("R10 clr");
    endtask

    task automatic t_stim_clear;
        step(1'b1, mk(0, 0, 11), 1'b1, 1'b1, "R11 set");
        step(1'b0, '0, 1'b0, 1'b0, "R11 both");
        check_bit("R11 fired old", exc_gate_n[11], 1'b0);
        step(1'b0, '0, 1'b1, 1'b0, "R11 after");
        check_bit("R11 released", exc_gate_n[11], 1'b1);
        idle("R11");
    endtask

    task automatic t_persist;
        step(1'b1, mk(2, 1, 2), 1'b1, 1'b1, "R12 set");
        for (int k = 0; k < 3; k++) begin
            step(1'b0, '0, 1'b1, 1'b0, "R12 stim");
            check_bit("R12 fires again", inh_gate_n[2*SP+2], 1'b0);
            idle("R12 gap");
        end
        wipe("R12 clr");
    endtask

    task automatic t_sweep;
        for (int br = 0; br < 4; br++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int pos = 0; pos < SP; pos++) begin
                    step(1'b1, mk(br, pol, pos), 1'b1, 1'b1, "R3 sweep set");
                    step(1'b0, '0, 1'b1, 1'b0, "R3 sweep stim");
                    wipe("R3 sweep clr");
                end
            end
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_pos15();
        t_polarity();
        t_clear();
        t_clear_set();
        t_set_in_stim();
        t_stim_clear();
        t_persist();
        t_sweep();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule